// File: doc/BRIEF.md
# Pin Control Bank with Bit Set and Clear Aliases

This block holds the configuration of a parameterised number of general purpose pins and drives the pad controls from it. Each pin has seven one-bit attributes (output enable, output level, pull enable, pull direction, receiver enable, Schmitt enable, plus a read-only sampled input) and a 3-bit function select. Software reaches all of it over a simple 32-bit register bus with a one-cycle write strobe and a registered read port.

Each one-bit attribute is packed sixteen pins to a word. Every such word is visible at three addresses: a plain address that replaces the word, a set address where each 1 in the write data forces the matching bit to 1, and a clear address where each 1 forces it to 0. This lets a driver flip a single pin without a read-modify-write. The function selects are packed five pins to a word, and a write picks the fields it updates through per-field select bits in the upper half of the data. Pad inputs cross into the clock domain through a two-flop synchroniser.

Addresses are word addresses: bits [1:0] pick the alias (0 plain, 1 set, 2 clear, 3 unused), bits [WIDX_W+1:2] the word index, and the top four bits the register kind: 0 output enable, 1 output level, 2 pull enable, 3 pull direction (1 = up), 4 receiver enable, 5 Schmitt enable, 6 sampled input, 7 pin value, 8 function select.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset every pin is an input (output enable 0) with output level 0, pull enable 0, pull direction 0, receiver enable 1, Schmitt enable 0 and function select 0; read data is 0.
- R2: Pin p sits at word index p/16, bit p%16 of each one-bit kind; bits of pins at or above NUM_PINS read 0 and cannot be set.
- R3: A write to the plain alias (address bits [1:0] = 0) replaces all stored bits of that word.
- R4: A write to the set alias (bits [1:0] = 1) sets each bit whose data bit is 1 and leaves the others unchanged.
- R5: A write to the clear alias (bits [1:0] = 2) clears each bit whose data bit is 1 and leaves the others unchanged.
- R6: A read at the plain, set or clear alias of a word returns its stored value; alias 3 reads 0 and ignores writes.
- R7: The sampled-input kind (6) ignores writes at every alias; a pad change becomes readable after two clock edges.
- R8: A pin whose receiver enable is 0 reads 0 in the sampled-input kind.
- R9: The pin value kind (7) returns the output level for pins with output enable 1 and the sampled input otherwise.
- R10: Pin p's 3-bit function select sits in function word p/5 at bits [3*(p%5)+2 : 3*(p%5)] and drives pin_mode[3p+2:3p].
- R11: A plain write to a function word updates field f only when data bit 16+f is 1; writes at the set or clear alias of a function word are ignored; bits 31:15 of a function word read 0.
- R12: The pad outputs equal the stored bits of their kinds and change only on a write.
- R13: Read data is registered: it updates one edge after bus_rd and holds otherwise; an unmapped kind reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | WIDX_W+6 | Word address: kind, word index, alias |
| bus_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_pull_en | output | NUM_PINS | Pull resistor enable |
| pad_pull_up | output | NUM_PINS | Pull direction, 1 = up |
| pad_ie | output | NUM_PINS | Receiver enable |
| pad_smt | output | NUM_PINS | Schmitt trigger enable |
| pin_mode | output | 3*NUM_PINS | Function select, 3 bits per pin |

## Verification
The bench builds the block with NUM_PINS = 21, so the second one-bit word holds only five live pins and the fifth function word holds a single field. That brings the zero-fill of absent pins, the masking of writes to them and the partly filled function word within reach, while sixteen full pins in the first word exercise every bit lane of the aliases.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // Register kinds, decoded from the top four address bits.
  localparam logic [3:0] K_DIR  = 4'd0;
  localparam logic [3:0] K_DOUT = 4'd1;
  localparam logic [3:0] K_PEN  = 4'd2;
  localparam logic [3:0] K_PSEL = 4'd3;
  localparam logic [3:0] K_IEN  = 4'd4;
  localparam logic [3:0] K_SMT  = 4'd5;
  localparam logic [3:0] K_DIN  = 4'd6;
  localparam logic [3:0] K_PVAL = 4'd7;
  localparam logic [3:0] K_MODE = 4'd8;

  typedef enum logic [1:0] {
    A_PLAIN = 2'd0,
    A_SET   = 2'd1,
    A_CLR   = 2'd2,
    A_NONE  = 2'd3
  } alias_e;

  localparam int CTL_KINDS     = 6;
  localparam int PINS_PER_WORD = 16;
  localparam int PINS_PER_MODE = 5;
  localparam int MODE_W        = 3;
  localparam int MODE_WORD_W   = PINS_PER_MODE * MODE_W;

endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg
  import gpio_alias_pkg::*;
#(
  parameter int   NUM_PINS = 20,
  parameter int   WIDX_W   = 4,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  alias_e              alias_sel,
  input  logic [WIDX_W-1:0]   word_idx,
  input  logic [15:0]         wdata,
  output logic [NUM_PINS-1:0] q
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
    localparam logic [WIDX_W-1:0] WSEL = WIDX_W'(p / PINS_PER_WORD);
    localparam int                BPOS = p % PINS_PER_WORD;

    logic en;
    logic nxt;
    logic q_r;

    always_comb begin
      en  = wr_hit && (word_idx == WSEL);
      nxt = q_r;
      unique case (alias_sel)
        A_PLAIN: nxt = wdata[BPOS];
        A_SET:   if (wdata[BPOS]) nxt = 1'b1;
        A_CLR:   if (wdata[BPOS]) nxt = 1'b0;
        default: nxt = q_r;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= RST_VAL;
      end else if (en) begin
        q_r <= nxt;
      end
    end

    assign q[p] = q_r;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_sync
);

  logic [NUM_PINS-1:0] meta_r;
  logic [NUM_PINS-1:0] stab_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_r <= '0;
      stab_r <= '0;
    end else begin
      meta_r <= pad_in;
      stab_r <= meta_r;
    end
  end

  assign pad_sync = stab_r;

endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
  import gpio_alias_pkg::*;
#(
  parameter int NUM_PINS = 20,
  parameter int WIDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDX_W-1:0]          word_idx,
  input  logic [MODE_WORD_W-1:0]     fields,
  input  logic [PINS_PER_MODE-1:0]   field_sel,
  output logic [MODE_W*NUM_PINS-1:0] mode
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [WIDX_W-1:0] RSEL = WIDX_W'(p / PINS_PER_MODE);
    localparam int                FPOS = p % PINS_PER_MODE;

    logic              en;
    logic [MODE_W-1:0] nxt;
    logic [MODE_W-1:0] q_r;

    always_comb begin
      en  = wr_en && (word_idx == RSEL) && field_sel[FPOS];
      nxt = fields[MODE_W*FPOS +: MODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
      end else if (en) begin
        q_r <= nxt;
      end
    end

    assign mode[MODE_W*p +: MODE_W] = q_r;
  end

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int NUM_PINS = 20,
  parameter int WIDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [WIDX_W+5:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                rsp_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_pull_en,
  output logic [NUM_PINS-1:0]        pad_pull_up,
  output logic [NUM_PINS-1:0]        pad_ie,
  output logic [NUM_PINS-1:0]        pad_smt,
  output logic [MODE_W*NUM_PINS-1:0] pin_mode
);

  localparam int PAD_W      = PINS_PER_WORD << WIDX_W;
  localparam int MODE_PAD_W = MODE_WORD_W << WIDX_W;
  localparam int BIDX_W     = WIDX_W + 4;

  // Reset: asynchronous assertion, synchronous release.
  logic rst_s1_r;
  logic rst_s2_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_r <= 1'b0;
      rst_s2_r <= 1'b0;
    end else begin
      rst_s1_r <= 1'b1;
      rst_s2_r <= rst_s1_r;
    end
  end

  logic rst_int_n;
  assign rst_int_n = rst_s2_r;

  // Address decode.
  logic [3:0]        kind;
  logic [WIDX_W-1:0] word_idx;
  alias_e            alias_sel;

  assign kind      = bus_addr[WIDX_W+5:WIDX_W+2];
  assign word_idx  = bus_addr[WIDX_W+1:2];
  assign alias_sel = alias_e'(bus_addr[1:0]);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:21];

  // One-bit control kinds.
  logic [NUM_PINS-1:0] ctl_q [CTL_KINDS];

  for (genvar g = 0; g < CTL_KINDS; g++) begin : g_ctl
    logic hit;
    assign hit = bus_wr && (kind == 4'(g));

    gpio_ctl_reg #(
      .NUM_PINS (NUM_PINS),
      .WIDX_W   (WIDX_W),
      .RST_VAL  ((g == int'(K_IEN)) ? 1'b1 : 1'b0)
    ) i_ctl (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_hit    (hit),
      .alias_sel (alias_sel),
      .word_idx  (word_idx),
      .wdata     (bus_wdata[15:0]),
      .q         (ctl_q[g])
    );
  end

  // Pad input path.
  logic [NUM_PINS-1:0] pad_sync;

  gpio_in_sync #(
    .NUM_PINS (NUM_PINS)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pad_in   (pad_in),
    .pad_sync (pad_sync)
  );

  logic [NUM_PINS-1:0] din_v;
  logic [NUM_PINS-1:0] pval_v;

  assign din_v  = pad_sync & ctl_q[K_IEN];
  assign pval_v = (ctl_q[K_DIR] & ctl_q[K_DOUT]) | (~ctl_q[K_DIR] & din_v);

  // Function selects.
  logic mode_wr;
  assign mode_wr = bus_wr && (kind == K_MODE) && (alias_sel == A_PLAIN);

  gpio_mode_bank #(
    .NUM_PINS (NUM_PINS),
    .WIDX_W   (WIDX_W)
  ) i_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (mode_wr),
    .word_idx  (word_idx),
    .fields    (bus_wdata[MODE_WORD_W-1:0]),
    .field_sel (bus_wdata[16 +: PINS_PER_MODE]),
    .mode      (pin_mode)
  );

  // Read path.
  logic [PAD_W-1:0]      rd_pad [CTL_KINDS+2];
  logic [MODE_PAD_W-1:0] mode_pad;
  logic [BIDX_W-1:0]     bit_base;
  logic [BIDX_W-1:0]     mode_base;

  for (genvar g = 0; g < CTL_KINDS; g++) begin : g_pad
    assign rd_pad[g] = PAD_W'(ctl_q[g]);
  end
  assign rd_pad[CTL_KINDS]   = PAD_W'(din_v);
  assign rd_pad[CTL_KINDS+1] = PAD_W'(pval_v);
  assign mode_pad            = MODE_PAD_W'(pin_mode);

  assign bit_base  = {word_idx, 4'b0000};
  assign mode_base = bit_base - {4'b0000, word_idx};

  logic [31:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (alias_sel != A_NONE) begin
      if (kind <= K_PVAL) begin
        rd_nxt = {16'h0000, rd_pad[kind[2:0]][bit_base +: PINS_PER_WORD]};
      end else if (kind == K_MODE) begin
        rd_nxt = {{(32-MODE_WORD_W){1'b0}}, mode_pad[mode_base +: MODE_WORD_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_rdata <= '0;
    end else if (bus_rd) begin
      rsp_rdata <= rd_nxt;
    end
  end

  // Pad outputs.
  assign pad_oe      = ctl_q[K_DIR];
  assign pad_out     = ctl_q[K_DOUT];
  assign pad_pull_en = ctl_q[K_PEN];
  assign pad_pull_up = ctl_q[K_PSEL];
  assign pad_ie      = ctl_q[K_IEN];
  assign pad_smt     = ctl_q[K_SMT];

endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk #(
  parameter int NUM_PINS = 20,
  parameter int WIDX_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [WIDX_W+5:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           rsp_rdata,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_pull_en,
  input logic [NUM_PINS-1:0]   pad_pull_up,
  input logic [NUM_PINS-1:0]   pad_ie,
  input logic [NUM_PINS-1:0]   pad_smt,
  input logic [3*NUM_PINS-1:0] pin_mode
);

  localparam int LOW = (NUM_PINS < 16) ? NUM_PINS : 16;

  logic [3:0]        kind;
  logic [WIDX_W-1:0] widx;
  logic [1:0]        al;
  logic              oe_w0;

  assign kind  = bus_addr[WIDX_W+5:WIDX_W+2];
  assign widx  = bus_addr[WIDX_W+1:2];
  assign al    = bus_addr[1:0];
  assign oe_w0 = bus_wr && (kind == 4'd0) && (widx == '0);

  p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_w0 && al == 2'd1) |=>
      ((pad_oe[LOW-1:0] & $past(pad_oe[LOW-1:0])) == $past(pad_oe[LOW-1:0])));

  p_set_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_w0 && al == 2'd1) |=>
      ((pad_oe[LOW-1:0] & $past(bus_wdata[LOW-1:0])) == $past(bus_wdata[LOW-1:0])));

  p_clr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_w0 && al == 2'd2) |=>
      ((pad_oe[LOW-1:0] & $past(bus_wdata[LOW-1:0])) == '0));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull_en) &&
                 $stable(pad_pull_up) && $stable(pad_ie) && $stable(pad_smt) &&
                 $stable(pin_mode)));

  p_din_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == 4'd6) |=> ($stable(pad_oe) && $stable(pad_out) &&
                                  $stable(pad_ie) && $stable(pin_mode)));

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rsp_rdata));

  p_mode_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && kind == 4'd8) |=> (rsp_rdata[31:15] == '0));

endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .WIDX_W   (WIDX_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rsp_rdata   (rsp_rdata),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .pad_pull_en (pad_pull_en),
  .pad_pull_up (pad_pull_up),
  .pad_ie      (pad_ie),
  .pad_smt     (pad_smt),
  .pin_mode    (pin_mode)
);

// File: tb/test_gpio_alias_bank.sv
module test_gpio_alias_bank;

  localparam int N  = 21;
  localparam int WW = 4;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [WW+5:0]     bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       rsp_rdata;
  logic [N-1:0]      pad_in;
  logic [N-1:0]      pad_oe;
  logic [N-1:0]      pad_out;
  logic [N-1:0]      pad_pull_en;
  logic [N-1:0]      pad_pull_up;
  logic [N-1:0]      pad_ie;
  logic [N-1:0]      pad_smt;
  logic [3*N-1:0]    pin_mode;

  gpio_alias_bank #(.NUM_PINS(N), .WIDX_W(WW)) i_gpio_alias_bank (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .rsp_rdata (rsp_rdata),
    .pad_in (pad_in), .pad_oe (pad_oe), .pad_out (pad_out),
    .pad_pull_en (pad_pull_en), .pad_pull_up (pad_pull_up),
    .pad_ie (pad_ie), .pad_smt (pad_smt), .pin_mode (pin_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // Behavioural reference state.
  logic [N-1:0] m_ctl [6];
  logic [N-1:0] m_s1, m_s2;
  logic [2:0]   m_mode [N];
  logic [31:0]  m_rd;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW+5:0] mk(input int k, input int w, input int a);
    return {4'(k), WW'(w), 2'(a)};
  endfunction

  function automatic logic [31:0] mread(input int k, input int w, input int a);
    logic [31:0] r = '0;
    logic [N-1:0] v;
    if (a == 3) return '0;
    if (k <= 7) begin
      if (k < 6)       v = m_ctl[k];
      else if (k == 6) v = m_s2 & m_ctl[4];
      else             v = (m_ctl[0] & m_ctl[1]) | (~m_ctl[0] & m_s2 & m_ctl[4]);
      for (int b = 0; b < 16; b++)
        if (w * 16 + b < N) r[b] = v[w * 16 + b];
    end else if (k == 8) begin
      for (int f = 0; f < 5; f++)
        if (w * 5 + f < N) r[3*f +: 3] = m_mode[w * 5 + f];
    end
    return r;
  endfunction

  task automatic mwrite(input int k, input int w, input int a, input logic [31:0] d);
    if (a == 3) return;
    if (k < 6) begin
      for (int b = 0; b < 16; b++) begin
        if (w * 16 + b < N) begin
          if (a == 0)                m_ctl[k][w*16+b] = d[b];
          else if (a == 1 && d[b])   m_ctl[k][w*16+b] = 1'b1;
          else if (a == 2 && d[b])   m_ctl[k][w*16+b] = 1'b0;
        end
      end
    end else if (k == 8 && a == 0) begin
      for (int f = 0; f < 5; f++)
        if (w * 5 + f < N && d[16+f]) m_mode[w*5+f] = d[3*f +: 3];
    end
  endtask

  task automatic compare_all(input string tag);
    logic [3*N-1:0] pm;
    for (int p = 0; p < N; p++) pm[3*p +: 3] = m_mode[p];
    chk(tag,   64'(rsp_rdata),   64'(m_rd));
    chk("R12", 64'(pad_oe),      64'(m_ctl[0]));
    chk("R12", 64'(pad_out),     64'(m_ctl[1]));
    chk("R12", 64'(pad_pull_en), 64'(m_ctl[2]));
    chk("R12", 64'(pad_pull_up), 64'(m_ctl[3]));
    chk("R12", 64'(pad_ie),      64'(m_ctl[4]));
    chk("R12", 64'(pad_smt),     64'(m_ctl[5]));
    chk("R10", 64'(pin_mode),    64'(pm));
  endtask

  task automatic step(input bit wr, input bit rd, input int k, input int w,
                      input int a, input logic [31:0] d, input string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = mk(k, w, a); bus_wdata = d;
    @(posedge clk);
    if (rd) m_rd = mread(k, w, a);
    m_s2 = m_s1;
    m_s1 = pad_in;
    if (wr) mwrite(k, w, a, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr(input int k, input int w, input int a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, k, w, a, d, tag);
  endtask

  task automatic rd(input int k, input int w, input int a, input string tag);
    step(1'b0, 1'b1, k, w, a, 32'h0, tag);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    for (int k = 0; k < 6; k++) m_ctl[k] = (k == 4) ? '1 : '0;
    for (int p = 0; p < N; p++) m_mode[p] = 3'd0;
    m_s1 = '0; m_s2 = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 0, 0, 0, 32'h0, "R1");

    // R1: reset contents through reads
    rd(4, 0, 0, "R1");
    rd(4, 1, 0, "R1");
    rd(1, 0, 0, "R1");
    rd(8, 0, 0, "R1");

    // R3 / R2: plain writes, partial second word
    wr(0, 0, 0, 32'hFFFF_A5A5, "R3");
    rd(0, 0, 0, "R3");
    wr(0, 1, 0, 32'h0000_FFFF, "R2");
    rd(0, 1, 0, "R2");
    wr(0, 1, 0, 32'h0000_0012, "R3");
    rd(0, 1, 0, "R2");

    // R4: set alias
    wr(1, 0, 1, 32'h0000_0003, "R4");
    wr(1, 0, 1, 32'h0000_8100, "R4");
    wr(0, 0, 1, 32'h0000_0A0A, "R4");
    rd(1, 0, 1, "R6");
    rd(0, 0, 1, "R6");

    // R5: clear alias
    wr(1, 0, 2, 32'h0000_0101, "R5");
    wr(0, 0, 2, 32'h0000_0005, "R5");
    rd(1, 0, 2, "R6");
    rd(0, 0, 2, "R6");
    wr(1, 0, 3, 32'hFFFF_FFFF, "R6");
    rd(1, 0, 3, "R6");
    rd(1, 0, 0, "R6");

    // R12: other pad controls
    wr(2, 0, 0, 32'h0000_F00F, "R12");
    wr(3, 0, 1, 32'h0000_3003, "R12");
    wr(5, 1, 1, 32'h0000_0011, "R12");
    wr(4, 1, 2, 32'h0000_0002, "R12");
    rd(5, 1, 0, "R12");

    // R7: synchroniser latency and read-only input word
    pad_in = 21'h1A_5C3E;
    rd(6, 0, 0, "R7");
    rd(6, 0, 0, "R7");
    rd(6, 0, 0, "R7");
    rd(6, 1, 0, "R7");
    wr(6, 0, 0, 32'h0000_0000, "R7");
    wr(6, 0, 1, 32'h0000_FFFF, "R7");
    wr(6, 1, 2, 32'h0000_FFFF, "R7");
    rd(6, 0, 1, "R7");
    rd(6, 1, 2, "R7");

    // R8: receiver disabled pins read 0
    wr(4, 0, 2, 32'h0000_00FF, "R8");
    rd(6, 0, 0, "R8");
    rd(6, 1, 0, "R8");

    // R9: pin value
    rd(7, 0, 0, "R9");
    rd(7, 1, 0, "R9");
    pad_in = 21'h05_A3C1;
    step(1'b0, 1'b0, 0, 0, 0, 32'h0, "R9");
    step(1'b0, 1'b0, 0, 0, 0, 32'h0, "R9");
    rd(7, 0, 0, "R9");
    rd(7, 1, 2, "R9");

    // R10 / R11: function selects
    wr(8, 0, 0, 32'h001F_7FFF, "R10");
    rd(8, 0, 0, "R10");
    wr(8, 1, 0, 32'h0015_5AC1, "R11");
    rd(8, 1, 0, "R11");
    wr(8, 0, 0, 32'h0002_0000, "R11");
    rd(8, 0, 0, "R11");
    wr(8, 4, 0, 32'hFFFF_FFFF, "R11");
    rd(8, 4, 0, "R11");
    wr(8, 0, 1, 32'h001F_0000, "R11");
    wr(8, 1, 2, 32'h001F_7FFF, "R11");
    rd(8, 1, 1, "R11");
    rd(8, 3, 0, "R10");

    // R13: hold, unmapped kinds
    repeat (3) step(1'b0, 1'b0, 8, 0, 0, 32'h0, "R13");
    rd(9, 0, 0, "R13");
    rd(15, 2, 0, "R13");
    wr(12, 0, 0, 32'hFFFF_FFFF, "R13");
    repeat (2) step(1'b0, 1'b0, 0, 0, 0, 32'h0, "R13");

    summary();
    $finish;
  end

endmodule